// File: doc/BRIEF.md
# Power-up reset sequencer

This block produces the chip's internal reset from four sources: power-on detect, an external active-low clear pin, a brown-out comparator output and a watchdog time-out. After power-on or a brown-out, it holds reset through two timers that run one after the other. The first is a power-up delay counted on strobes from a separate slow oscillator. The second is a start-up count of main-oscillator cycles, which lets the crystal settle. After both timers, reset is released only when the external clear pin is high.

A watchdog time-out, or the clear pin going low during normal operation, gives a short fixed reset pulse and skips both timers. The analog detectors are outside the block and arrive as digital inputs.

Two sticky, active-low cause flags record power-on and brown-out events. Hardware clears them and software sets them through a small write port. After a reset, firmware can read them to tell a cold start from a brown-out recovery.

Top module: `pwr_rst_seq`

## Requirements
- R1: While rst_ni (the power-on detect) is low, rst_o is 1 and both flags read 0. After rst_ni rises, the sequence starts at the power-up delay.
- R2: When pwrt_en_i or bor_en_i is 1, the power-up delay holds rst_o high for PWRT_TICKS pulses of slow_tick_i (default 8). When both are 0, the delay is skipped after one clock.
- R3: After the delay, the start-up count holds rst_o high for OST_CYCLES pulses of osc_tick_i (default 1024, a 10-bit count) when ost_en_i is 1. When ost_en_i is 0, the count is skipped after one clock.
- R4: After both timers, rst_o falls only on the clock after ext_clr_ni is sampled high. While the pin stays low, reset is held for any length of time.
- R5: When bor_en_i and bor_det_i are both 1 at a clock edge, rst_o is 1 from the next cycle on, whatever the current phase. When bor_en_i is 0, bor_det_i has no effect on rst_o.
- R6: When bor_det_i falls, the power-up delay restarts from zero, then the start-up count follows. A new brown-out during the delay restarts the delay again.
- R7: During normal operation, wdt_to_i high or ext_clr_ni low drives rst_o high for exactly PULSE_CYCLES clocks (default 4), with no delay and no start-up count. Release then follows the rule of R4.
- R8: On a clock with flag_we_i high, flag_wdata_i bit 1 is loaded into por_flag_o and bit 0 is loaded into bor_flag_o. Without a write, the flags hold their values.
- R9: An active brown-out clears bor_flag_o to 0, and this takes priority over a write in the same cycle. A watchdog or pin reset leaves both flags unchanged.
- R10: wdt_to_i is ignored while reset is already asserted. It does not shorten or restart the power-up delay or the start-up count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Power-on detect, active low, asynchronous |
| slow_tick_i | input | 1 | Strobe from the slow oscillator, one clock wide |
| osc_tick_i | input | 1 | Main-oscillator cycle strobe |
| ext_clr_ni | input | 1 | External clear pin, active low |
| bor_det_i | input | 1 | Brown-out comparator output, 1 = supply below trip |
| wdt_to_i | input | 1 | Watchdog time-out |
| pwrt_en_i | input | 1 | Power-up delay enable |
| bor_en_i | input | 1 | Brown-out reset enable (also forces the delay on) |
| ost_en_i | input | 1 | Start-up count enable |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag write data: bit 1 power-on, bit 0 brown-out |
| rst_o | output | 1 | Internal reset, active high |
| por_flag_o | output | 1 | Power-on flag, 0 after power-on |
| bor_flag_o | output | 1 | Brown-out flag, 0 after brown-out |

## Verification
The assertions check, on every cycle, the relations between neighbouring cycles:
- brown-out forcing reset and clearing its flag on the next cycle;
- release only after a high pin sample;
- a watchdog hit in run entering the pulse;
- restart after brown-out recovery;
- flag stability and timer counts staying below their limits.

The exact lengths of the delay, the start-up count and the pulse, and nested brown-outs during the delay, can only be shown by the bench's scenarios. The same applies to skipping the timers when disabled and to a watchdog being ignored while in reset. There, a behavioural model predicts rst_o and both flags on every clock.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [2:0] {
    ST_PWRT  = 3'd0,
    ST_OST   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_RUN   = 3'd3,
    ST_PULSE = 3'd4,
    ST_BROWN = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT)) else $error("timer count overran"); // R2 R3
endmodule

// File: rtl/pwr_rst_fsm.sv
module pwr_rst_fsm
  import pwr_rst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bor_hit_i,
  input  logic       pwrt_on_i,
  input  logic       ost_en_i,
  input  logic       ext_clr_ni,
  input  logic       wdt_to_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  input  logic       pulse_done_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (bor_hit_i) begin
      state_d = ST_BROWN;
    end else begin
      unique case (state_q)
        ST_BROWN: state_d = ST_PWRT;
        ST_PWRT:  if (!pwrt_on_i || pwrt_done_i) state_d = ST_OST;
        ST_OST:   if (!ost_en_i || ost_done_i)   state_d = ST_HOLD;
        ST_HOLD:  if (ext_clr_ni)                state_d = ST_RUN;
        ST_RUN:   if (!ext_clr_ni || wdt_to_i)   state_d = ST_PULSE;
        ST_PULSE: if (pulse_done_i)              state_d = ST_HOLD;
        default:  state_d = ST_PWRT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_WDT_GIVES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wdt_to_i && !bor_hit_i) |=> state_q == ST_PULSE)
    else $error("watchdog in run did not pulse"); // R7
  AST_BROWN_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BROWN && !bor_hit_i) |=> state_q == ST_PWRT)
    else $error("brown-out recovery did not restart delay"); // R6
endmodule

// File: rtl/pwr_rst_flags.sv
module pwr_rst_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bor_hit_i,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic       por_flag_o,
  output logic       bor_flag_o
);
  logic por_q, bor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q <= 1'b0;
      bor_q <= 1'b0;
    end else begin
      if (we_i) por_q <= wdata_i[1];
      if (bor_hit_i) bor_q <= 1'b0;
      else if (we_i) bor_q <= wdata_i[0];
    end
  end

  assign por_flag_o = por_q;
  assign bor_flag_o = bor_q;

  AST_BOR_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_hit_i |=> !bor_flag_o) else $error("brown-out flag not cleared"); // R9
  AST_POR_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(por_flag_o)) else $error("power-on flag moved"); // R8
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int PWRT_TICKS   = 8,
  parameter int OST_CYCLES   = 1024,
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_tick_i,
  input  logic       osc_tick_i,
  input  logic       ext_clr_ni,
  input  logic       bor_det_i,
  input  logic       wdt_to_i,
  input  logic       pwrt_en_i,
  input  logic       bor_en_i,
  input  logic       ost_en_i,
  input  logic       flag_we_i,
  input  logic [1:0] flag_wdata_i,
  output logic       rst_o,
  output logic       por_flag_o,
  output logic       bor_flag_o
);
  seq_state_e state;
  logic bor_hit, pwrt_on;
  logic pwrt_done, ost_done, pulse_done;

  assign bor_hit = bor_en_i && bor_det_i;
  // brown-out reset requires the power-up delay
  assign pwrt_on = pwrt_en_i || bor_en_i;

  pwr_rst_timer #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk_i, .rst_ni,
    .run_i (state == ST_PWRT && pwrt_on),
    .tick_i(slow_tick_i),
    .done_o(pwrt_done)
  );

  pwr_rst_timer #(.LIMIT(OST_CYCLES)) u_ost (
    .clk_i, .rst_ni,
    .run_i (state == ST_OST && ost_en_i),
    .tick_i(osc_tick_i),
    .done_o(ost_done)
  );

  pwr_rst_timer #(.LIMIT(PULSE_CYCLES)) u_pulse (
    .clk_i, .rst_ni,
    .run_i (state == ST_PULSE),
    .tick_i(1'b1),
    .done_o(pulse_done)
  );

  pwr_rst_fsm u_fsm (
    .clk_i, .rst_ni,
    .bor_hit_i   (bor_hit),
    .pwrt_on_i   (pwrt_on),
    .ost_en_i,
    .ext_clr_ni,
    .wdt_to_i,
    .pwrt_done_i (pwrt_done),
    .ost_done_i  (ost_done),
    .pulse_done_i(pulse_done),
    .state_o     (state)
  );

  pwr_rst_flags u_flags (
    .clk_i, .rst_ni,
    .bor_hit_i (bor_hit),
    .we_i      (flag_we_i),
    .wdata_i   (flag_wdata_i),
    .por_flag_o,
    .bor_flag_o
  );

  assign rst_o = (state != ST_RUN);

  AST_BOR_FORCES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_en_i && bor_det_i) |=> rst_o) else $error("brown-out left reset low"); // R5
  AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(ext_clr_ni)) else $error("released with pin low"); // R4
endmodule

// File: tb/pwr_rst_seq_test.sv
module pwr_rst_seq_test;
  localparam int PWRT = 8;
  localparam int OST = 1024;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, osc_tick = 1'b0, ext_n = 1'b1, bor_det = 1'b0, wdt = 1'b0;
  logic pwrt_en = 1'b1, bor_en = 1'b1, ost_en = 1'b1, we = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic rst_o, por_f, bor_f;

  always #4 clk = ~clk;

  pwr_rst_seq #(.PWRT_TICKS(PWRT), .OST_CYCLES(OST), .PULSE_CYCLES(PULSE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow_tick), .osc_tick_i(osc_tick),
    .ext_clr_ni(ext_n), .bor_det_i(bor_det), .wdt_to_i(wdt), .pwrt_en_i(pwrt_en),
    .bor_en_i(bor_en), .ost_en_i(ost_en), .flag_we_i(we), .flag_wdata_i(wdata),
    .rst_o(rst_o), .por_flag_o(por_f), .bor_flag_o(bor_f));

  int checks = 0, errors = 0;
  int cyc = 0;
  bit cmp_on = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // tick generators: slow every 16 clocks, oscillator every other clock
  always @(negedge clk) begin
    cyc <= cyc + 1;
    slow_tick <= ((cyc + 1) % 16 == 0);
    osc_tick <= ~osc_tick;
  end

  // behavioural reference: phase 0 delay,1 start-up,2 wait pin,3 run,4 pulse,5 brown
  int ph, n;
  bit e_por, e_bor, from_brown;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; n = 0; e_por = 0; e_bor = 0; from_brown = 0;
    end else begin
      if (we) e_por = wdata[1];
      if (bor_en && bor_det) e_bor = 0;
      else if (we) e_bor = wdata[0];
      if (bor_en && bor_det) begin
        ph = 5; n = 0;
      end else begin
        case (ph)
          5: begin ph = 0; n = 0; from_brown = 1; end
          0: if (!(pwrt_en || bor_en)) begin ph = 1; n = 0; from_brown = 0; end
             else if (slow_tick) begin
               n++;
               if (n == PWRT) begin ph = 1; n = 0; from_brown = 0; end
             end
          1: if (!ost_en) begin ph = 2; n = 0; end
             else if (osc_tick) begin
               n++;
               if (n == OST) begin ph = 2; n = 0; end
             end
          2: if (ext_n) ph = 3;
          3: if (!ext_n || wdt) begin ph = 4; n = 0; end
          4: begin n++; if (n == PULSE) begin ph = 2; n = 0; end end
          default: ph = 0;
        endcase
      end
    end
  end

  function automatic string tag_of(int p, bit fb);
    case (p)
      0: return fb ? "R6" : "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(rst_o == (ph != 3), tag_of(ph, from_brown), rst_o, ph != 3);
      check(por_f == e_por, "R8 por flag", por_f, e_por);
      check(bor_f == e_bor, "R8/R9 bor flag", bor_f, e_bor);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 6000; i++) begin
      if (!rst_o) break;
      @(negedge clk);
    end
  endtask

  initial begin
    step(3);
    check(rst_o == 1'b1, "R1 reset during power-on", rst_o, 1);
    check(por_f == 1'b0, "R1 por flag", por_f, 0);
    check(bor_f == 1'b0, "R1 bor flag", bor_f, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    step(20);
    check(rst_o == 1'b1, "R2 held in delay", rst_o, 1);
    wait_release();
    check(rst_o == 1'b0, "R4 released after timers", rst_o, 0);

    // R8 software sets flags
    we = 1'b1; wdata = 2'b11; step(1);
    we = 1'b0; wdata = 2'b00; step(1);
    check(por_f == 1'b1, "R8 por set", por_f, 1);
    check(bor_f == 1'b1, "R8 bor set", bor_f, 1);

    // R7 watchdog pulse
    wdt = 1'b1; step(1); wdt = 1'b0; step(1);
    check(rst_o == 1'b1, "R7 watchdog pulse", rst_o, 1);
    step(PULSE + 2);
    check(rst_o == 1'b0, "R7 pulse ended", rst_o, 0);
    check(por_f == 1'b1 && bor_f == 1'b1, "R9 flags kept after watchdog", {por_f, bor_f}, 3);

    // R4 pin held low past the pulse
    ext_n = 1'b0; step(30);
    check(rst_o == 1'b1, "R4 held while pin low", rst_o, 1);
    ext_n = 1'b1; step(2);
    check(rst_o == 1'b0, "R4 released on pin high", rst_o, 0);

    // R5/R9 brown-out, R6 nested restart, R10 watchdog ignored
    bor_det = 1'b1; we = 1'b1; wdata = 2'b11; step(1); we = 1'b0; step(4);
    check(rst_o == 1'b1, "R5 brown-out reset", rst_o, 1);
    check(bor_f == 1'b0, "R9 bor flag cleared", bor_f, 0);
    check(por_f == 1'b1, "R9 por flag kept", por_f, 1);
    bor_det = 1'b0; step(40);
    bor_det = 1'b1; step(2); bor_det = 1'b0;
    step(10); wdt = 1'b1; step(1); wdt = 1'b0;
    step(90);
    check(rst_o == 1'b1, "R6 delay restarted", rst_o, 1);
    check(rst_o == 1'b1, "R10 watchdog ignored in reset", rst_o, 1);
    wait_release();
    check(rst_o == 1'b0, "R6 released after restart", rst_o, 0);

    // R5 brown-out disabled
    we = 1'b1; wdata = 2'b11; step(1); we = 1'b0;
    bor_en = 1'b0; bor_det = 1'b1; step(5);
    check(rst_o == 1'b0, "R5 disabled brown-out ignored", rst_o, 0);
    check(bor_f == 1'b1, "R5 disabled brown-out keeps flag", bor_f, 1);
    bor_det = 1'b0;

    // R2/R3 both timers skipped
    pwrt_en = 1'b0; ost_en = 1'b0;
    cmp_on = 0; rst_n = 1'b0; step(2);
    check(por_f == 1'b0, "R1 por flag cleared again", por_f, 0);
    rst_n = 1'b1; cmp_on = 1; step(1);
    check(rst_o == 1'b1, "R2 one clock in skipped delay", rst_o, 1);
    step(3);
    check(rst_o == 1'b0, "R3 timers skipped", rst_o, 0);
    step(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule